// File: doc/BRIEF.md
# Dual-Setpoint Up/Down Preset Counter

This block keeps a present count that moves by one on each qualified count pulse, upwards or downwards as a direction bit selects, inside the range 0 to 999999 with wrap-around at both ends. Two setpoints are compared against the count. Each setpoint drives one output channel whose behaviour depends on the direction in which the count arrives at that setpoint.

Two output modes exist. In the level mode, channel A is active while the count lies below its setpoint and channel B is active at or above its own. Each channel changes state only when the count steps onto its setpoint, and the direction of that step decides the new state. In the pulse mode, each channel emits a one-shot whose length is a programmable number of tick-enable periods every time the count steps onto its setpoint from either side.

A separate clear input is qualified by a programmable minimum width. A clear pulse that is long enough zeroes the count, forces both outputs inactive and freezes counting until the clear input drops. On release, the level-mode outputs are re-derived from the count. The output mode is sampled only while a qualified clear is being held.

Top module: `dual_setpoint_counter`

## Requirements
- R1: The count `pv` never exceeds 999999. A count pulse (`cnt_evt`=1 at a clock edge while counting is enabled) moves `pv` by one at that edge: up when `cnt_down`=0, down when `cnt_down`=1. All outputs are registers that change at that same edge.
- R2: Reaching a setpoint never stops, holds or reloads the count. Later pulses keep moving it past either setpoint.
- R3: Level mode (`pulse_mode`=0 latched), channel A: `out_a` goes to 0 on an upward step that lands on `sp_a` and goes to 1 on a downward step that lands on `sp_a`. Otherwise it holds its state.
- R4: Level mode, channel B: `out_b` goes to 1 on an upward step that lands on `sp_b` and goes to 0 on a downward step that lands on `sp_b`. Otherwise it holds its state.
- R5: Pulse mode (`pulse_mode`=1 latched): a step in either direction that lands on `sp_a` sets `out_a` to 1 at that edge. It then stays high until `width_a` clock edges with `tick`=1 have passed, and it drops at the last of them. Channel B does the same with `sp_b` and `width_b`. A width of 0 gives no pulse.
- R6: When `clr_in` has been sampled high on `max(clr_min,1)` consecutive edges, then at the last of those edges `pv` becomes 0 and both outputs become 0. Count pulses are ignored while the clear is held. The system reset `rst` enters the same held state.
- R7: The held state ends at the first edge that samples `clr_in`=0. Count pulses at that edge are still ignored. Pulses from the following edge on are counted.
- R8: A clear pulse shorter than `max(clr_min,1)` consecutive samples has no effect on the count, the outputs or counting.
- R9: An upward pulse at 999999 gives 0, and a downward pulse at 0 gives 999999. Each is a single step.
- R10: In pulse mode, landing on a setpoint again while that channel's pulse is still active restarts its full width.
- R11: At the release edge of R7, level mode sets `out_a` to (count < `sp_a`) and `out_b` to (count >= `sp_b`), with the count being 0. Pulse mode leaves both outputs at 0.
- R12: The mode is latched from `pulse_mode` only during `rst` or while the clear is held with `clr_in` still high. A change of `pulse_mode` at any other time has no effect on output behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| cnt_evt | input | 1 | One-cycle count pulse |
| cnt_down | input | 1 | Direction: 0 up, 1 down |
| clr_in | input | 1 | Raw clear request, level |
| clr_min | input | 16 | Minimum clear width in clock samples (0 acts as 1) |
| tick | input | 1 | Time base enable for the pulse timers |
| pulse_mode | input | 1 | Output mode request: 0 level, 1 pulse |
| sp_a | input | 20 | Setpoint of channel A |
| sp_b | input | 20 | Setpoint of channel B |
| width_a | input | 16 | Pulse width of channel A in ticks |
| width_b | input | 16 | Pulse width of channel B in ticks |
| pv | output | 20 | Present count |
| out_a | output | 1 | Channel A output |
| out_b | output | 1 | Channel B output |

## Verification
Each count pulse updates the count and both level-mode outputs at the very edge that samples it, so the bench drives inputs on falling edges and reads results on the following falling edge. A qualified clear takes effect at the edge that takes the `clr_min`-th high sample, and the re-derived level outputs appear at the first edge that sees `clr_in` low. The bench counts those edges exactly before it checks. Pulse-mode outputs are checked on every cycle after a hit: high for exactly the programmed number of tick edges and low on the next one, and a restart is confirmed by the output still being high after the original pulse would have ended.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  typedef enum logic {
    MODE_LEVEL = 1'b0,
    MODE_PULSE = 1'b1
  } out_mode_e;

  // Next count value for one step, wrapping in [0, max_v]
  function automatic logic [19:0] step_value(input logic [19:0] cur,
                                             input logic        down,
                                             input logic [19:0] max_v);
    logic [19:0] r;
    if (down) r = (cur == '0) ? max_v : cur - 20'd1;
    else      r = (cur == max_v) ? '0 : cur + 20'd1;
    return r;
  endfunction

endpackage

// File: rtl/dsc_clr_qual.sv
module dsc_clr_qual #(
  parameter int QW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_in,
  input  logic [QW-1:0] clr_min,
  output logic          held,
  output logic          clr_now,
  output logic          release_now
);

  logic [QW-1:0] run_q;
  logic [QW:0]   need;
  logic [QW:0]   seen;

  assign need        = (clr_min == '0) ? {{QW{1'b0}}, 1'b1} : {1'b0, clr_min};
  assign seen        = {1'b0, run_q} + {{QW{1'b0}}, 1'b1};
  assign clr_now     = clr_in && !held && (seen >= need);
  assign release_now = held && !clr_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
      held  <= 1'b1;
    end else begin
      if (!clr_in)           run_q <= '0;
      else if (run_q != '1)  run_q <= run_q + 1'b1;

      if (clr_now)           held <= 1'b1;
      else if (release_now)  held <= 1'b0;
    end
  end

endmodule

// File: rtl/dsc_pv_counter.sv
module dsc_pv_counter
  import dsc_pkg::*;
#(
  parameter int          PV_W   = 20,
  parameter logic [19:0] PV_MAX = 20'd999999
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            evt,
  input  logic            down,
  input  logic            inhibit,
  input  logic            clear,
  output logic            step,
  output logic [PV_W-1:0] pv_q,
  output logic [PV_W-1:0] pv_nxt
);

  assign step   = evt && !inhibit && !clear;
  assign pv_nxt = PV_W'(step_value(20'(pv_q), down, PV_MAX));

  always_ff @(posedge clk) begin
    if (rst || clear) pv_q <= '0;
    else if (step)    pv_q <= pv_nxt;
  end

endmodule

// File: rtl/dsc_out_chan.sv
module dsc_out_chan
  import dsc_pkg::*;
#(
  parameter int PV_W    = 20,
  parameter int TW      = 16,
  parameter bit UP_SETS = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            release_now,
  input  out_mode_e       mode,
  input  logic            step,
  input  logic            down,
  input  logic [PV_W-1:0] pv_q,
  input  logic [PV_W-1:0] pv_nxt,
  input  logic [PV_W-1:0] sp,
  input  logic [TW-1:0]   width,
  input  logic            tick,
  output logic            out
);

  logic [TW-1:0] tmr_q;
  logic          hit;
  logic          rel_level;

  assign hit = step && (pv_nxt == sp);

  generate
    if (UP_SETS) begin : g_above
      assign rel_level = (pv_q >= sp);
    end else begin : g_below
      assign rel_level = (pv_q < sp);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      out   <= 1'b0;
      tmr_q <= '0;
    end else if (release_now) begin
      tmr_q <= '0;
      out   <= (mode == MODE_LEVEL) ? rel_level : 1'b0;
    end else if (mode == MODE_PULSE) begin
      if (hit) begin
        tmr_q <= width;
        out   <= (width != '0);
      end else if (tick && tmr_q != '0) begin
        tmr_q <= tmr_q - 1'b1;
        if (tmr_q == {{(TW-1){1'b0}}, 1'b1}) out <= 1'b0;
      end
    end else begin
      tmr_q <= '0;
      if (hit) out <= UP_SETS ? !down : down;
    end
  end

endmodule

// File: rtl/dual_setpoint_counter.sv
module dual_setpoint_counter
  import dsc_pkg::*;
#(
  parameter int          PV_W   = 20,
  parameter logic [19:0] PV_MAX = 20'd999999,
  parameter int          TW     = 16,
  parameter int          QW     = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cnt_evt,
  input  logic            cnt_down,
  input  logic            clr_in,
  input  logic [QW-1:0]   clr_min,
  input  logic            tick,
  input  logic            pulse_mode,
  input  logic [PV_W-1:0] sp_a,
  input  logic [PV_W-1:0] sp_b,
  input  logic [TW-1:0]   width_a,
  input  logic [TW-1:0]   width_b,
  output logic [PV_W-1:0] pv,
  output logic            out_a,
  output logic            out_b
);

  localparam int NCH = 2;

  logic            held_q;
  logic            clr_now;
  logic            release_now;
  logic            step;
  logic [PV_W-1:0] pv_nxt;
  out_mode_e       mode_q;

  logic [PV_W-1:0] sp_arr    [NCH];
  logic [TW-1:0]   width_arr [NCH];
  logic            out_arr   [NCH];

  assign sp_arr[0]    = sp_a;
  assign sp_arr[1]    = sp_b;
  assign width_arr[0] = width_a;
  assign width_arr[1] = width_b;
  assign out_a        = out_arr[0];
  assign out_b        = out_arr[1];

  // Mode is sampled only while a qualified clear is still asserted
  always_ff @(posedge clk) begin
    if (rst || (held_q && clr_in)) mode_q <= out_mode_e'(pulse_mode);
  end

  dsc_clr_qual #(.QW(QW)) i_qual (
    .clk         (clk),
    .rst         (rst),
    .clr_in      (clr_in),
    .clr_min     (clr_min),
    .held        (held_q),
    .clr_now     (clr_now),
    .release_now (release_now)
  );

  dsc_pv_counter #(.PV_W(PV_W), .PV_MAX(PV_MAX)) i_cnt (
    .clk     (clk),
    .rst     (rst),
    .evt     (cnt_evt),
    .down    (cnt_down),
    .inhibit (held_q),
    .clear   (clr_now),
    .step    (step),
    .pv_q    (pv),
    .pv_nxt  (pv_nxt)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      dsc_out_chan #(.PV_W(PV_W), .TW(TW), .UP_SETS(c == 1)) i_ch (
        .clk         (clk),
        .rst         (rst),
        .clear       (clr_now),
        .release_now (release_now),
        .mode        (mode_q),
        .step        (step),
        .down        (cnt_down),
        .pv_q        (pv),
        .pv_nxt      (pv_nxt),
        .sp          (sp_arr[c]),
        .width       (width_arr[c]),
        .tick        (tick),
        .out         (out_arr[c])
      );
    end
  endgenerate

endmodule

// File: rtl/dsc_checker.sv
module dsc_checker
  import dsc_pkg::*;
#(
  parameter int          PV_W   = 20,
  parameter logic [19:0] PV_MAX = 20'd999999,
  parameter int          TW     = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            cnt_down,
  input logic [PV_W-1:0] pv,
  input logic            out_a,
  input logic            out_b,
  input logic [PV_W-1:0] sp_a,
  input logic [PV_W-1:0] sp_b,
  input logic [TW-1:0]   width_a,
  input logic [TW-1:0]   width_b,
  input logic            held,
  input logic            step,
  input logic [PV_W-1:0] pv_nxt,
  input out_mode_e       mode_q
);

  localparam logic [PV_W-1:0] MAXV = PV_W'(PV_MAX);

  AST_PV_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    pv <= MAXV); // R1

  AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
    (step && !cnt_down) |=> pv == (($past(pv) == MAXV) ? '0 : $past(pv) + 1'b1)); // R9

  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
    (step && cnt_down) |=> pv == (($past(pv) == '0) ? MAXV : $past(pv) - 1'b1)); // R1

  AST_HELD_QUIET: assert property (@(posedge clk) disable iff (rst)
    held |-> (pv == '0 && !out_a && !out_b)); // R6

  AST_LVL_A_UP_OFF: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_LEVEL && step && !cnt_down && pv_nxt == sp_a) |=> !out_a); // R3

  AST_LVL_B_UP_ON: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_LEVEL && step && !cnt_down && pv_nxt == sp_b) |=> out_b); // R4

  AST_PULSE_A_FIRE: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_PULSE && step && pv_nxt == sp_a && width_a != '0) |=> out_a); // R5

  AST_PULSE_B_FIRE: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_PULSE && step && pv_nxt == sp_b && width_b != '0) |=> out_b); // R5

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !held |=> $stable(mode_q)); // R12

endmodule

bind dual_setpoint_counter dsc_checker #(.PV_W(PV_W), .PV_MAX(PV_MAX), .TW(TW)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .cnt_down (cnt_down),
  .pv       (pv),
  .out_a    (out_a),
  .out_b    (out_b),
  .sp_a     (sp_a),
  .sp_b     (sp_b),
  .width_a  (width_a),
  .width_b  (width_b),
  .held     (held_q),
  .step     (step),
  .pv_nxt   (pv_nxt),
  .mode_q   (mode_q)
);

// File: tb/test_dual_setpoint_counter.sv
`timescale 1ns/1ps
module test_dual_setpoint_counter;

  localparam int PV_W = 20;
  localparam int TW   = 16;
  localparam int QW   = 16;
  localparam longint MAXV = 999999;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            cnt_evt = 1'b0;
  logic            cnt_down = 1'b0;
  logic            clr_in = 1'b0;
  logic [QW-1:0]   clr_min = 16'd4;
  logic            tick = 1'b1;
  logic            pulse_mode = 1'b0;
  logic [PV_W-1:0] sp_a = 20'd5;
  logic [PV_W-1:0] sp_b = 20'd8;
  logic [TW-1:0]   width_a = 16'd3;
  logic [TW-1:0]   width_b = 16'd2;
  logic [PV_W-1:0] pv;
  logic            out_a;
  logic            out_b;

  int n_chk  = 0;
  int n_fail = 0;
  longint exp_pv = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dual_setpoint_counter i_dual_setpoint_counter (
    .clk(clk), .rst(rst), .cnt_evt(cnt_evt), .cnt_down(cnt_down),
    .clr_in(clr_in), .clr_min(clr_min), .tick(tick), .pulse_mode(pulse_mode),
    .sp_a(sp_a), .sp_b(sp_b), .width_a(width_a), .width_b(width_b),
    .pv(pv), .out_a(out_a), .out_b(out_b)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  // Apply n count pulses; returns at the falling edge after the last one
  task automatic count(input int n, input bit down);
    for (int i = 0; i < n; i++) begin
      cnt_down = down;
      cnt_evt  = 1'b1;
      @(negedge clk);
      if (down) exp_pv = (exp_pv == 0) ? MAXV : exp_pv - 1;
      else      exp_pv = (exp_pv == MAXV) ? 0 : exp_pv + 1;
    end
    cnt_evt = 1'b0;
  endtask

  // Clear held for n samples then released; returns after the release edge
  task automatic hold_clear(input int n, input bit mode);
    pulse_mode = mode;
    clr_in = 1'b1;
    repeat (n) @(negedge clk);
    clr_in = 1'b0;
    @(negedge clk);
    exp_pv = 0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R6 reset pv", pv, 0);
    chk("R6 reset out_a", out_a, 0);
    chk("R6 reset out_b", out_b, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 release out_a", out_a, 1);
    chk("R11 release out_b", out_b, 0);
  endtask

  task automatic t_level();
    count(4, 0);
    chk("R1 pv up", pv, exp_pv);
    chk("R3 below sp_a", out_a, 1);
    count(1, 0);
    chk("R3 up onto sp_a", out_a, 0);
    count(2, 0);
    chk("R4 below sp_b", out_b, 0);
    count(1, 0);
    chk("R4 up onto sp_b", out_b, 1);
    count(2, 0);
    chk("R2 past setpoints", pv, 10);
    chk("R2 out_b held", out_b, 1);
    count(2, 1);
    chk("R1 pv down", pv, exp_pv);
    chk("R4 down onto sp_b", out_b, 0);
    count(2, 1);
    chk("R3 above sp_a on way down", out_a, 0);
    count(1, 1);
    chk("R3 down onto sp_a", out_a, 1);
  endtask

  task automatic t_mode_ignored();
    pulse_mode = 1'b1;
    count(1, 1);
    count(1, 0);
    chk("R12 mode change not latched", out_a, 0);
    @(negedge clk);
    chk("R12 still level", out_a, 0);
    pulse_mode = 1'b0;
  endtask

  task automatic t_short_clear();
    clr_in = 1'b1;
    repeat (3) @(negedge clk);
    clr_in = 1'b0;
    @(negedge clk);
    chk("R8 short clear pv", pv, 5);
    chk("R8 short clear out_b", out_b, 0);
    count(1, 0);
    chk("R8 counting unaffected", pv, 6);
  endtask

  task automatic t_held_clear();
    clr_in = 1'b1;
    repeat (4) @(negedge clk);
    exp_pv = 0;
    chk("R6 qualified clear pv", pv, 0);
    chk("R6 qualified clear out_b", out_b, 0);
    cnt_down = 1'b0;
    cnt_evt  = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6 pulses ignored while held", pv, 0);
    clr_in = 1'b0;
    @(negedge clk);
    cnt_evt = 1'b0;
    chk("R7 release edge pulse ignored", pv, 0);
    chk("R11 level re-eval out_a", out_a, 1);
    chk("R11 level re-eval out_b", out_b, 0);
    count(1, 0);
    chk("R7 counting resumes", pv, 1);
  endtask

  task automatic t_wrap();
    count(2, 1);
    chk("R9 down wrap", pv, MAXV);
    chk("R9 down wrap value model", pv, exp_pv);
    chk("R9 out_a unchanged", out_a, 1);
    count(1, 0);
    chk("R9 up wrap", pv, 0);
  endtask

  task automatic t_pulse();
    sp_a = 20'd2;
    sp_b = 20'd4;
    clr_min = 16'd0;
    hold_clear(2, 1);
    chk("R11 pulse release out_a", out_a, 0);
    chk("R11 pulse release out_b", out_b, 0);
    count(1, 0);
    chk("R5 no hit", out_a, 0);
    count(1, 0);
    for (int k = 0; k < 3; k++) begin
      chk("R5 out_a high", out_a, 1);
      @(negedge clk);
    end
    chk("R5 out_a ends after width", out_a, 0);
    count(1, 1);
    count(1, 0);
    chk("R10 second hit", out_a, 1);
    count(1, 1);
    count(1, 0);
    for (int k = 0; k < 3; k++) begin
      chk("R10 restarted width", out_a, 1);
      @(negedge clk);
    end
    chk("R10 ends after restart", out_a, 0);
    count(2, 0);
    chk("R5 up onto sp_b", out_b, 1);
    count(1, 0);
    chk("R5 out_b second tick", out_b, 1);
    @(negedge clk);
    chk("R5 out_b ends", out_b, 0);
    count(1, 1);
    chk("R5 down onto sp_b", out_b, 1);
    chk("R1 pv model", pv, exp_pv);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_level();
    t_mode_ignored();
    t_short_clear();
    t_held_clear();
    t_wrap();
    t_pulse();
    done = 1'b1;
    report();
  end

endmodule